// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This controller-side block moves a DDR2-class SDRAM into self-refresh and brings it back out. When the memory controller asks for a low-power retention period and every bank is closed, the sequencer first pulls on-die termination low. It holds NOP with the clock-enable pin high for a programmable settling time. It then issues the self-refresh command in the same cycle that CKE goes low. While the device retains data on its own timer, the block deasserts a clock-gate enable so the memory clock can be stopped.

A wake request restarts the clock and lets it run for a programmable number of stable cycles before CKE is raised. From the CKE rise the block drives NOP on every cycle. It grants non-read commands after the shorter exit timeout and reads after the longer one. Termination is released together with the read grant. Two request/grant pairs let the rest of the controller hold off reads and other commands until the matching grant is present. All intervals are parameters: `T_AOFD`, `T_STAB`, `T_XSNR` and `T_XSRD`, with `T_XSRD > T_XSNR`.

Top module: `dram_sr_seq`

## Requirements
- R1: After reset: `cke_o`=1, command NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), `clk_en_o`=1, `odt_en_o`=1, `rd_ok_o`=1, `cmd_ok_o`=1, `busy_o`=0.
- R2: `sr_req_i` sampled high on a clock edge starts entry only while the block is idle and `banks_idle_i` is high. A request made while a bank is open changes no output.
- R3: Once entry is accepted, from the next cycle `busy_o`=1, `odt_en_o`=0, `rd_ok_o`=0 and `cmd_ok_o`=0. NOP is driven with CKE high for exactly `T_AOFD` cycles. The next cycle carries the self-refresh command {0,0,0,1} with `cke_o`=0.
- R4: After the self-refresh command cycle, `cke_o` stays 0 and the command is deselect (4'b1111) until the exit begins. `cke_o` never falls except in a self-refresh command cycle.
- R5: `clk_en_o` is 0 from the cycle after the self-refresh command until a wake request is sampled. It is then 1 from the next cycle, and `cke_o` rises after exactly `T_STAB` cycles of running clock.
- R6: From the cycle in which `cke_o` rises, NOP is driven on every cycle with CKE high. `cmd_ok_o` rises `T_XSNR` cycles after the rise.
- R7: `rd_ok_o` and `odt_en_o` rise, and `busy_o` falls, `T_XSRD` cycles after the CKE rise. `odt_en_o` is never 1 while `rd_ok_o` is 0.
- R8: `rd_go_o` = `rd_req_i` AND `rd_ok_o`, and `cmd_go_o` = `cmd_req_i` AND `cmd_ok_o`. A request without its grant is held off.
- R9: A wake request outside self-refresh has no effect. An entry request while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_req_i | input | 1 | Request to enter self-refresh |
| banks_idle_i | input | 1 | All banks precharged with tRP met |
| wake_i | input | 1 | Request to leave self-refresh |
| rd_req_i | input | 1 | Controller wants to issue a read |
| cmd_req_i | input | 1 | Controller wants to issue a non-read command |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| clk_en_o | output | 1 | Memory clock gate enable |
| odt_en_o | output | 1 | Termination permitted |
| rd_ok_o | output | 1 | Read timeout met |
| cmd_ok_o | output | 1 | Non-read timeout met |
| busy_o | output | 1 | Entry/exit sequence in progress |
| rd_go_o | output | 1 | Read request granted |
| cmd_go_o | output | 1 | Non-read request granted |

## Verification
The assertions check several rules on every cycle:
- CKE falls only together with the self-refresh command.
- Termination has been off for at least `T_AOFD` cycles when that command appears.
- CKE is never high while the clock is gated, and it rises only after `T_STAB` cycles of running clock.
- NOP is driven throughout the exit until the non-read grant.
- Termination never leads the read grant, and the read grant never leads the non-read grant.

Only the bench scenarios can show the exact interval lengths. They also show that requests made with an open bank or while busy are ignored, that wakes outside self-refresh are ignored, and that grant timing holds across repeated entries with short and long sleeps.

// File: rtl/dram_sr_pkg.sv
package dram_sr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ODT_OFF,
    ST_SRE,
    ST_SR,
    ST_STAB,
    ST_EXIT
  } sr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_DES = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_SRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sr_fsm.sv
module sr_fsm
  import dram_sr_pkg::*;
#(
  parameter int unsigned T_AOFD = 3,
  parameter int unsigned T_STAB = 8,
  parameter int unsigned T_XSRD = 200,
  parameter int unsigned CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             wake_i,
  output sr_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o
);

  sr_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  localparam logic [CNT_W-1:0] AOFD_LAST = CNT_W'(T_AOFD - 1);
  localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(T_STAB - 1);
  localparam logic [CNT_W-1:0] XSRD_LAST = CNT_W'(T_XSRD - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (enter_i) state_d = ST_ODT_OFF;
      end
      ST_ODT_OFF: if (cnt_q == AOFD_LAST) begin
        state_d = ST_SRE;
        cnt_d   = '0;
      end
      ST_SRE: begin
        state_d = ST_SR;
        cnt_d   = '0;
      end
      ST_SR: begin
        cnt_d = '0;
        if (wake_i) state_d = ST_STAB;
      end
      ST_STAB: if (cnt_q == STAB_LAST) begin
        state_d = ST_EXIT;
        cnt_d   = '0;
      end
      ST_EXIT: if (cnt_q == XSRD_LAST) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  // R9: wake has no effect during entry
  a_r9_wake_ignored_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ODT_OFF) |=> (state_q inside {ST_ODT_OFF, ST_SRE}));

  // R5: device stays in self-refresh until a wake
  a_r5_sr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SR && !wake_i) |=> (state_q == ST_SR));

endmodule

// File: rtl/sr_out.sv
module sr_out
  import dram_sr_pkg::*;
#(
  parameter int unsigned T_XSNR = 24,
  parameter int unsigned CNT_W  = 8
) (
  input  sr_state_e        state_i,
  input  logic [CNT_W-1:0] cnt_i,
  output dram_cmd_t        cmd_o,
  output logic             cke_o,
  output logic             clk_en_o,
  output logic             odt_en_o,
  output logic             rd_ok_o,
  output logic             cmd_ok_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] XSNR_CNT = CNT_W'(T_XSNR);

  always_comb begin
    cmd_o    = CMD_NOP;
    cke_o    = 1'b1;
    clk_en_o = 1'b1;
    odt_en_o = 1'b0;
    rd_ok_o  = 1'b0;
    cmd_ok_o = 1'b0;
    busy_o   = 1'b1;
    unique case (state_i)
      ST_IDLE: begin
        odt_en_o = 1'b1;
        rd_ok_o  = 1'b1;
        cmd_ok_o = 1'b1;
        busy_o   = 1'b0;
      end
      ST_ODT_OFF: ;
      ST_SRE: begin
        cmd_o = CMD_SRE;
        cke_o = 1'b0;
      end
      ST_SR: begin
        cmd_o    = CMD_DES;
        cke_o    = 1'b0;
        clk_en_o = 1'b0;
      end
      ST_STAB: begin
        cmd_o = CMD_DES;
        cke_o = 1'b0;
      end
      ST_EXIT: cmd_ok_o = (cnt_i >= XSNR_CNT);
      default: ;
    endcase
  end

endmodule

// File: rtl/sr_gate.sv
module sr_gate (
  input  logic rd_req_i,
  input  logic cmd_req_i,
  input  logic rd_ok_i,
  input  logic cmd_ok_i,
  output logic rd_go_o,
  output logic cmd_go_o
);

  assign rd_go_o  = rd_req_i & rd_ok_i;
  assign cmd_go_o = cmd_req_i & cmd_ok_i;

endmodule

// File: rtl/dram_sr_seq.sv
module dram_sr_seq
  import dram_sr_pkg::*;
#(
  parameter int unsigned T_AOFD = 3,
  parameter int unsigned T_STAB = 8,
  parameter int unsigned T_XSNR = 24,
  parameter int unsigned T_XSRD = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_req_i,
  input  logic banks_idle_i,
  input  logic wake_i,
  input  logic rd_req_i,
  input  logic cmd_req_i,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic clk_en_o,
  output logic odt_en_o,
  output logic rd_ok_o,
  output logic cmd_ok_o,
  output logic busy_o,
  output logic rd_go_o,
  output logic cmd_go_o
);

  localparam int unsigned M1    = (T_AOFD > T_STAB) ? T_AOFD : T_STAB;
  localparam int unsigned M2    = (M1 > T_XSRD) ? M1 : T_XSRD;
  localparam int unsigned CNT_W = $clog2(M2 + 1);

  sr_state_e        state;
  logic [CNT_W-1:0] cnt;
  dram_cmd_t        cmd;
  logic             enter;

  // entry is qualified here; sr_fsm only acts on it in idle
  assign enter = sr_req_i & banks_idle_i;

  sr_fsm #(
    .T_AOFD(T_AOFD), .T_STAB(T_STAB), .T_XSRD(T_XSRD), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .enter_i(enter),
    .wake_i (wake_i),
    .state_o(state),
    .cnt_o  (cnt)
  );

  sr_out #(
    .T_XSNR(T_XSNR), .CNT_W(CNT_W)
  ) u_out (
    .state_i (state),
    .cnt_i   (cnt),
    .cmd_o   (cmd),
    .cke_o   (cke_o),
    .clk_en_o(clk_en_o),
    .odt_en_o(odt_en_o),
    .rd_ok_o (rd_ok_o),
    .cmd_ok_o(cmd_ok_o),
    .busy_o  (busy_o)
  );

  sr_gate u_gate (
    .rd_req_i (rd_req_i),
    .cmd_req_i(cmd_req_i),
    .rd_ok_i  (rd_ok_o),
    .cmd_ok_i (cmd_ok_o),
    .rd_go_o  (rd_go_o),
    .cmd_go_o (cmd_go_o)
  );

  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;

  initial begin
    a_params: assert (T_AOFD >= 1 && T_STAB >= 1 && T_XSNR >= 1 && T_XSRD > T_XSNR);
  end

  // checker counters: consecutive cycles with termination off / clock running
  logic [15:0] odt_off_cnt, clk_run_cnt;
  logic        sre_seen;
  logic        nop_seen;

  assign sre_seen = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001);
  assign nop_seen = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odt_off_cnt <= '0;
      clk_run_cnt <= '0;
    end else begin
      odt_off_cnt <= odt_en_o ? '0 : ((odt_off_cnt == 16'hFFFF) ? odt_off_cnt : odt_off_cnt + 1'b1);
      clk_run_cnt <= !clk_en_o ? '0 : ((clk_run_cnt == 16'hFFFF) ? clk_run_cnt : clk_run_cnt + 1'b1);
    end
  end

  a_r3_odt_off_before_sre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sre_seen |-> (!odt_en_o && 32'(odt_off_cnt) >= T_AOFD));

  a_r4_cke_falls_on_sre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> sre_seen);

  a_r5_no_cke_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> !cke_o);

  a_r5_clk_stable_at_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (clk_en_o && 32'(clk_run_cnt) >= T_STAB));

  a_r6_exit_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cke_o && !cmd_ok_o) |-> nop_seen);

  a_r7_rd_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok_o |-> cmd_ok_o);

  a_r7_odt_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odt_en_o |-> rd_ok_o);

  a_r8_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ok_o |-> !rd_go_o) and (!cmd_ok_o |-> !cmd_go_o));

endmodule

// File: tb/dram_sr_seq_test.sv
module dram_sr_seq_test;

  localparam int AOFD = 3;
  localparam int STAB = 5;
  localparam int XSNR = 12;
  localparam int XSRD = 40;

  localparam int P_IDLE = 0, P_ODT = 1, P_SRE = 2, P_SR = 3, P_STAB = 4, P_EXIT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 1'b0, banks_idle = 1'b0, wake = 1'b0, rd_req = 1'b0, cmd_req = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, clk_en, odt_en, rd_ok, cmd_ok, busy, rd_go, cmd_go;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dram_sr_seq #(.T_AOFD(AOFD), .T_STAB(STAB), .T_XSNR(XSNR), .T_XSRD(XSRD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sr_req_i(sr_req), .banks_idle_i(banks_idle),
    .wake_i(wake), .rd_req_i(rd_req), .cmd_req_i(cmd_req), .cke_o(cke),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .clk_en_o(clk_en), .odt_en_o(odt_en), .rd_ok_o(rd_ok), .cmd_ok_o(cmd_ok),
    .busy_o(busy), .rd_go_o(rd_go), .cmd_go_o(cmd_go)
  );

  // reference model: timestamps of accepted entry and wake
  int  cyc = 0;
  bit  active = 0, woke = 0;
  int  t_acc = 0, t_wk = 0;

  function automatic int phase(int c);
    int e, w;
    if (!active) return P_IDLE;
    e = c - t_acc;
    if (e < AOFD) return P_ODT;
    if (e == AOFD) return P_SRE;
    if (!woke) return P_SR;
    w = c - t_wk;
    if (w < STAB) return P_STAB;
    if (w - STAB < XSRD) return P_EXIT;
    return P_IDLE;
  endfunction

  function automatic int exit_k(int c);
    return c - t_wk - STAB;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      active = 0;
      woke   = 0;
      cyc    = 0;
    end else begin
      int ph;
      ph = phase(cyc);
      if (ph == P_IDLE) begin
        active = 0;
        if (sr_req && banks_idle) begin
          active = 1;
          woke   = 0;
          t_acc  = cyc + 1;
        end
      end else if (ph == P_SR && wake) begin
        woke = 1;
        t_wk = cyc + 1;
      end
      cyc = cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int ph, k;
      logic [3:0] e_cmd;
      logic e_cke, e_clk, e_odt, e_rd, e_cok, e_busy;
      ph = phase(cyc);
      k  = exit_k(cyc);
      e_cmd = 4'b0111; e_cke = 1; e_clk = 1; e_odt = 0; e_rd = 0; e_cok = 0; e_busy = 1;
      case (ph)
        P_IDLE: begin e_odt = 1; e_rd = 1; e_cok = 1; e_busy = 0; end
        P_SRE:  begin e_cmd = 4'b0001; e_cke = 0; end
        P_SR:   begin e_cmd = 4'b1111; e_cke = 0; e_clk = 0; end
        P_STAB: begin e_cmd = 4'b1111; e_cke = 0; end
        P_EXIT: e_cok = (k >= XSNR);
        default: ;
      endcase
      chk({cs_n, ras_n, cas_n, we_n} == e_cmd, "R3 command", int'({cs_n, ras_n, cas_n, we_n}), int'(e_cmd));
      chk(cke == e_cke, "R4 cke", int'(cke), int'(e_cke));
      chk(clk_en == e_clk, "R5 clk_en", int'(clk_en), int'(e_clk));
      chk(cmd_ok == e_cok, "R6 cmd_ok", int'(cmd_ok), int'(e_cok));
      chk(rd_ok == e_rd, "R7 rd_ok", int'(rd_ok), int'(e_rd));
      chk(odt_en == e_odt, "R7 odt_en", int'(odt_en), int'(e_odt));
      chk(busy == e_busy, "R2 busy", int'(busy), int'(e_busy));
      chk(rd_go == (rd_req & e_rd), "R8 rd_go", int'(rd_go), int'(rd_req & e_rd));
      chk(cmd_go == (cmd_req & e_cok), "R8 cmd_go", int'(cmd_go), int'(cmd_req & e_cok));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk(cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && clk_en && odt_en && rd_ok && cmd_ok && !busy,
        "R1 reset state", int'({cke, clk_en, odt_en, rd_ok, cmd_ok, busy}), 6'b111110);

    // R2: request with an open bank is ignored
    step(1);
    sr_req = 1'b1;
    step(3);
    sr_req = 1'b0;
    @(negedge clk);
    chk(!busy && odt_en && cke, "R2 open bank ignored", int'({busy, odt_en, cke}), 3'b011);

    // first sequence, requests held to observe hold-off
    step(1);
    rd_req = 1'b1; cmd_req = 1'b1; banks_idle = 1'b1; sr_req = 1'b1;
    step(1);
    sr_req = 1'b0; wake = 1'b1;
    step(1);
    wake = 1'b0;
    @(negedge clk);
    // R9: wake during entry ignored
    chk(!odt_en && busy && cke, "R9 wake during entry", int'({odt_en, busy, cke}), 3'b011);
    step(15);
    sr_req = 1'b1;
    step(1);
    sr_req = 1'b0;
    @(negedge clk);
    // R9: request while busy ignored, still in self-refresh
    chk(!cke && !clk_en && busy, "R9 request while busy", int'({cke, clk_en, busy}), 3'b001);
    step(1);
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    step(XSRD + STAB + 5);
    @(negedge clk);
    chk(rd_ok && cmd_ok && odt_en && !busy, "R7 sequence complete", int'({rd_ok, cmd_ok, odt_en, busy}), 4'b1110);

    // second sequence: long sleep, wake held high
    step(1);
    rd_req = 1'b0;
    sr_req = 1'b1;
    step(1);
    sr_req = 1'b0;
    step(100);
    wake = 1'b1;
    step(10);
    wake = 1'b0;
    step(XSRD + 5);

    // third: request arrives before banks close, accepted once they do
    banks_idle = 1'b0; sr_req = 1'b1; cmd_req = 1'b0; rd_req = 1'b1;
    step(4);
    banks_idle = 1'b1;
    step(1);
    sr_req = 1'b0;
    step(AOFD + 8);
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    step(STAB + XSRD + 6);
    @(negedge clk);
    chk(!busy && rd_go, "R8 read granted after exit", int'({busy, rd_go}), 2'b01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule